// File: doc/BRIEF.md
# Pipelined Byte-Write Synchronous SRAM

This block is a single-port synchronous memory of 18-bit words, each split into two 9-bit byte lanes. All inputs except the output enable are captured on the rising clock edge: the access address, the chip select, the global write, the write enable, the per-lane write enables and the write data. On the following edge the captured request either writes the selected lanes into the array or loads the addressed word into an output register. The output register drives the data output from that edge on. Read data therefore appears two rising edges after the address was presented.

An upstream burst sequencer supplies one address per cycle. The block only decodes and executes each access. The output enable acts without the clock. The pad-drive flag `dq_en` models the high-impedance state: when it is low the data output is not driven, and `dq` reads as zero. The array depth comes from the address-width parameter, so simulation can use a small array.

Top module: `pbw_sram`

## Requirements
- R1: While reset is high and after it is released, `dq_en` is low and `dq` is zero until the first read reaches the output register.
- R2: A selected cycle with `gw_n` low writes both lanes with `wdata`, whatever the levels of `we_n` and `bw_n`.
- R3: A selected cycle with `gw_n` high and `we_n` low writes only the lanes whose `bw_n` bit is low. Bit 0 controls lane a (`wdata[8:0]`) and bit 1 controls lane b (`wdata[17:9]`). The other lane keeps its contents.
- R4: A selected cycle that enables no lane is a read: `gw_n` high with `we_n` high, or `we_n` low with `bw_n` = 2'b11. The array is left unchanged.
- R5: Read data for an address presented before edge k is on `dq`, with `dq_en` high, after edge k+1 and not before. Back-to-back reads stream one word per cycle.
- R6: `oe_n` high forces `dq_en` low and `dq` to zero immediately, with no clock edge. Lowering it again restores the held word.
- R7: The result of a write cycle or a deselected cycle (`sel_n` high) leaves `dq_en` low after edge k+1, whatever the level of `oe_n`.
- R8: A deselected cycle writes nothing, even with `gw_n` low.
- R9: A read in the cycle right after a write to the same address returns the newly written word.
- R10: The output register keeps its last value across cycles that perform no read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Chip select, active low |
| addr | input | ADDR_W | Word address from the burst sequencer |
| gw_n | input | 1 | Global write, active low, writes both lanes |
| we_n | input | 1 | Write enable qualifying `bw_n`, active low |
| bw_n | input | 2 | Per-lane write enables, active low (bit 0 lane a, bit 1 lane b) |
| wdata | input | 18 | Write data, captured with the address |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq | output | 18 | Read data, zero when not driven |
| dq_en | output | 1 | High while `dq` is driven onto the pads |

## Verification
The hardest case to reach is a read that follows a write to the same address directly. The array must already hold the new word when the read address is applied. The bench issues a global write and then a read of that address on consecutive clock edges. It checks the word that arrives two edges later. It also drives two reads back to back to show that the output register reloads every cycle while the earlier result is still visible.

// File: rtl/sram_pkg.sv
package sram_pkg;

    localparam int BYTE_W    = 9;
    localparam int NUM_BYTES = 2;
    localparam int WORD_W    = BYTE_W * NUM_BYTES;

    typedef logic [NUM_BYTES-1:0] lane_mask_t;
    typedef logic [WORD_W-1:0]    word_t;

    // Captured request, converted to active-high polarity
    typedef struct packed {
        logic       sel;
        logic       gw;
        logic       we;
        lane_mask_t bw;
    } req_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_e;

    // Lane write mask: global write overrides the qualified lane enables
    function automatic lane_mask_t lane_mask(input req_t r);
        lane_mask_t m;
        if (!r.sel)     m = '0;
        else if (r.gw)  m = '1;
        else if (r.we)  m = r.bw;
        else            m = '0;
        return m;
    endfunction

    function automatic op_e classify(input req_t r);
        op_e o;
        if (!r.sel)                 o = OP_IDLE;
        else if (lane_mask(r) != 0) o = OP_WRITE;
        else                        o = OP_READ;
        return o;
    endfunction

endpackage

// File: rtl/sram_in_stage.sv
module sram_in_stage
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   sel_n,
    input  logic [ADDR_W-1:0]      addr,
    input  logic                   gw_n,
    input  logic                   we_n,
    input  logic [NUM_BYTES-1:0]   bw_n,
    input  logic [WORD_W-1:0]      wdata,
    output req_t                   req_q,
    output logic [ADDR_W-1:0]      addr_q,
    output word_t                  wdata_q
);

    req_t req_d;

    always_comb begin
        req_d.sel = ~sel_n;
        req_d.gw  = ~gw_n;
        req_d.we  = ~we_n;
        req_d.bw  = ~bw_n;
    end

    // Control is reset to a deselected request; address and data are not
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    always_ff @(posedge clk) begin
        addr_q  <= addr;
        wdata_q <= wdata;
    end

endmodule

// File: rtl/sram_wr_decode.sv
module sram_wr_decode
    import sram_pkg::*;
(
    input  req_t       req,
    output lane_mask_t wmask,
    output op_e        op
);

    always_comb begin
        wmask = lane_mask(req);
        op    = classify(req);
    end

endmodule

// File: rtl/sram_array.sv
module sram_array
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] addr,
    input  lane_mask_t        wmask,
    input  word_t             wdata,
    output word_t             rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];

        always_ff @(posedge clk) begin
            if (wmask[g]) begin
                mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
            end
        end

        assign rdata[g*BYTE_W +: BYTE_W] = mem[addr];
    end

endmodule

// File: rtl/sram_out_stage.sv
module sram_out_stage
    import sram_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  op_e   op,
    input  word_t rdata,
    input  logic  oe_n,
    output word_t rd_q,
    output logic  drv_q,
    output word_t dq,
    output logic  dq_en
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q  <= '0;
            drv_q <= 1'b0;
        end else begin
            drv_q <= (op == OP_READ);
            if (op == OP_READ) begin
                rd_q <= rdata;
            end
        end
    end

    // Output enable gates the pads without the clock
    always_comb begin
        dq_en = drv_q & ~oe_n;
        dq    = dq_en ? rd_q : '0;
    end

endmodule

// File: rtl/pbw_sram.sv
module pbw_sram
    import sram_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sel_n,
    input  logic [ADDR_W-1:0]    addr,
    input  logic                 gw_n,
    input  logic                 we_n,
    input  logic [NUM_BYTES-1:0] bw_n,
    input  logic [WORD_W-1:0]    wdata,
    input  logic                 oe_n,
    output logic [WORD_W-1:0]    dq,
    output logic                 dq_en
);

    req_t              req_q;
    logic [ADDR_W-1:0] addr_q;
    word_t             wdata_q;
    lane_mask_t        wmask;
    op_e               op;
    word_t             rdata;
    word_t             rd_q;
    logic              drv_q;

    sram_in_stage #(.ADDR_W(ADDR_W)) u_in (
        .clk     (clk),
        .rst     (rst),
        .sel_n   (sel_n),
        .addr    (addr),
        .gw_n    (gw_n),
        .we_n    (we_n),
        .bw_n    (bw_n),
        .wdata   (wdata),
        .req_q   (req_q),
        .addr_q  (addr_q),
        .wdata_q (wdata_q)
    );

    sram_wr_decode u_dec (
        .req   (req_q),
        .wmask (wmask),
        .op    (op)
    );

    sram_array #(.ADDR_W(ADDR_W)) u_arr (
        .clk   (clk),
        .addr  (addr_q),
        .wmask (wmask),
        .wdata (wdata_q),
        .rdata (rdata)
    );

    sram_out_stage u_out (
        .clk   (clk),
        .rst   (rst),
        .op    (op),
        .rdata (rdata),
        .oe_n  (oe_n),
        .rd_q  (rd_q),
        .drv_q (drv_q),
        .dq    (dq),
        .dq_en (dq_en)
    );

endmodule

// File: rtl/sram_chk.sv
module sram_chk
    import sram_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 sel_n,
    input logic                 gw_n,
    input logic                 we_n,
    input logic [NUM_BYTES-1:0] bw_n,
    input logic                 oe_n,
    input logic                 dq_en,
    input logic [WORD_W-1:0]    dq,
    input logic [WORD_W-1:0]    rd_q
);

    logic wr_req, rd_req;
    assign wr_req = !sel_n && (!gw_n || (!we_n && !(&bw_n)));
    assign rd_req = !sel_n && !wr_req;

    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> !dq_en);

    a_r5_read_drives: assert property (@(posedge clk) disable iff (rst)
        rd_req |=> ##1 (dq_en == !oe_n));

    a_r6_oe_blocks: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (!dq_en && dq == '0));

    a_r7_write_quiet: assert property (@(posedge clk) disable iff (rst)
        wr_req |=> ##1 !dq_en);

    a_r7_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        sel_n |=> ##1 !dq_en);

    a_r10_hold_out: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> ##1 $stable(rd_q));

endmodule

bind pbw_sram sram_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .sel_n (sel_n),
    .gw_n  (gw_n),
    .we_n  (we_n),
    .bw_n  (bw_n),
    .oe_n  (oe_n),
    .dq_en (dq_en),
    .dq    (dq),
    .rd_q  (rd_q)
);

// File: tb/sim_pbw_sram.sv
`timescale 1ns/1ps
module sim_pbw_sram;

    localparam int AW = 6;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_n, gw_n, we_n, oe_n;
    logic [AW-1:0] addr;
    logic [1:0]  bw_n;
    logic [17:0] wdata;
    logic [17:0] dq;
    logic        dq_en;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    pbw_sram #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .sel_n(sel_n), .addr(addr), .gw_n(gw_n),
        .we_n(we_n), .bw_n(bw_n), .wdata(wdata), .oe_n(oe_n),
        .dq(dq), .dq_en(dq_en)
    );

    task automatic chk(input string req, input logic [18:0] act, input logic [18:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic s, input logic g, input logic w, input logic [1:0] b,
                         input logic [AW-1:0] a, input logic [17:0] d);
        sel_n = s; gw_n = g; we_n = w; bw_n = b; addr = a; wdata = d;
    endtask

    task automatic idle();
        drive(1'b1, 1'b1, 1'b1, 2'b11, '0, '0);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic gwrite(input logic [AW-1:0] a, input logic [17:0] d);
        drive(1'b0, 1'b0, 1'b1, 2'b11, a, d); step(); idle();
    endtask

    // Read, then sample after the second rising edge: {dq_en, dq}
    task automatic rd_check(input string req, input logic [AW-1:0] a, input logic [17:0] exp);
        drive(1'b0, 1'b1, 1'b1, 2'b11, a, 18'h0); step(); idle(); step();
        chk(req, {dq_en, dq}, {1'b1, exp});
    endtask

    task automatic t_reset();
        rst = 1'b1; oe_n = 1'b0; idle();
        repeat (3) step();
        chk("R1 in reset", {dq_en, dq}, 19'h0);
        rst = 1'b0; step(); step();
        chk("R1 after reset", {dq_en, dq}, 19'h0);
    endtask

    task automatic t_global();
        gwrite(6'd5, 18'h2A5A5);
        rd_check("R2 gw plain", 6'd5, 18'h2A5A5);
        drive(1'b0, 1'b0, 1'b0, 2'b10, 6'd5, 18'h15A5A); step(); idle();
        rd_check("R2 gw overrides bw", 6'd5, 18'h15A5A);
    endtask

    task automatic t_lanes();
        gwrite(6'd7, 18'h3FFFF);
        drive(1'b0, 1'b1, 1'b0, 2'b10, 6'd7, 18'h00000); step(); idle();
        rd_check("R3 lane a only", 6'd7, 18'h3FE00);
        drive(1'b0, 1'b1, 1'b0, 2'b01, 6'd7, 18'h00000); step(); idle();
        rd_check("R3 lane b only", 6'd7, 18'h00000);
        drive(1'b0, 1'b1, 1'b0, 2'b00, 6'd7, 18'h2468A); step(); idle();
        rd_check("R3 both lanes", 6'd7, 18'h2468A);
    endtask

    task automatic t_noop();
        gwrite(6'd9, 18'h12345);
        drive(1'b0, 1'b1, 1'b0, 2'b11, 6'd9, 18'h3FFFF); step(); idle(); step();
        chk("R4 no lane is read", {dq_en, dq}, {1'b1, 18'h12345});
        rd_check("R4 array unchanged", 6'd9, 18'h12345);
    endtask

    task automatic t_latency();
        gwrite(6'd1, 18'h11111);
        gwrite(6'd2, 18'h22222);
        step();
        drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd1, 18'h0); step();
        drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd2, 18'h0);
        chk("R5 not after one edge", {18'h0, dq_en}, 19'h0);
        step(); idle();
        chk("R5 first word", {dq_en, dq}, {1'b1, 18'h11111});
        step();
        chk("R5 second word", {dq_en, dq}, {1'b1, 18'h22222});
    endtask

    task automatic t_oe();
        rd_check("R6 setup read", 6'd2, 18'h22222);
        #1 oe_n = 1'b1; #1;
        chk("R6 oe high blocks", {dq_en, dq}, 19'h0);
        oe_n = 1'b0; #1;
        chk("R6 oe low restores", {dq_en, dq}, {1'b1, 18'h22222});
        step();
    endtask

    task automatic t_quiet();
        drive(1'b0, 1'b1, 1'b0, 2'b10, 6'd20, 18'h00001); step(); idle(); step();
        chk("R7 write cycle quiet", {18'h0, dq_en}, 19'h0);
        step();
        chk("R7 desel cycle quiet", {18'h0, dq_en}, 19'h0);
    endtask

    task automatic t_desel();
        gwrite(6'd30, 18'h0F0F0);
        drive(1'b1, 1'b0, 1'b0, 2'b00, 6'd30, 18'h3FFFF); step(); idle();
        rd_check("R8 desel writes nothing", 6'd30, 18'h0F0F0);
    endtask

    task automatic t_raw();
        drive(1'b0, 1'b0, 1'b1, 2'b11, 6'd40, 18'h3C3C3); step();
        drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd40, 18'h0); step(); idle();
        chk("R9 write result quiet", {18'h0, dq_en}, 19'h0);
        step();
        chk("R9 read after write", {dq_en, dq}, {1'b1, 18'h3C3C3});
    endtask

    task automatic t_hold();
        rd_check("R10 setup read", 6'd40, 18'h3C3C3);
        gwrite(6'd41, 18'h00007);
        repeat (2) step();
        oe_n = 1'b1; #1;
        drive(1'b0, 1'b1, 1'b1, 2'b11, 6'd41, 18'h0); step(); idle(); step();
        chk("R10 held while blocked", {dq_en, dq}, 19'h0);
        oe_n = 1'b0; #1;
        chk("R10 new read lands", {dq_en, dq}, {1'b1, 18'h00007});
        step();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        t_reset();
        t_global();
        t_lanes();
        t_noop();
        t_latency();
        t_oe();
        t_quiet();
        t_desel();
        t_raw();
        t_hold();
        done = 1'b1;
        report();
    end

    initial begin
        #200000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            report();
        end
    end

endmodule